// File: doc/BRIEF.md
# Iterative AES-256 Block Encryptor

This block enciphers one 128-bit data block under a 256-bit cipher key with the AES-256 forward cipher. A single round datapath is reused once per clock for all fourteen rounds. The opening key whitening happens while the inputs are loaded, and the shortened last round comes from a flag that bypasses the column mixing. The round keys are produced on the fly next to the rounds. Only the two most recent round keys are stored, and the next one is derived from them in the same cycle as the round that uses the current one.

A user presents plaintext and key together with a one-cycle start strobe while the block is idle. The block raises busy for fourteen cycles, then pulses done for one cycle. The ciphertext stays on its output until the next accepted start. A start that arrives while busy is high is dropped. A start given in the same cycle as done is accepted, so blocks can be issued back to back with no idle cycle between them.

Top module: `aes256_enc`

## Requirements
- R1: For any 256-bit key and 128-bit plaintext, the ciphertext equals the standard AES-256 forward cipher; key 000102…1f with plaintext 00112233445566778899aabbccddeeff gives 8ea2b7ca516745bfeafc49904b496089.
- R2: Byte n of a 128-bit vector occupies bits [127-8n -: 8]. The state is filled column-major: byte n sits in column n/4, row n mod 4. The key is ordered the same way, with key byte 0 in bits [255:248].
- R3: The cipher XORs the first round key into the state before round 1. Rounds 1 to 13 apply byte substitution, row shifting, column mixing and key addition. Round 14 omits the column mixing.
- R4: Round key k (k = 2..14) is derived from round keys k-2 and k-1. Even k uses rotate, substitute and the round constant with index k/2, where the constants are 01 doubled in GF(2^8). Odd k uses substitution only.
- R5: A start sampled while busy is low is accepted. Busy is then high for exactly 14 cycles, with the round counter running 1 to 14.
- R6: Done is high for exactly one cycle, in the cycle that follows the 14th rising edge after the edge that accepted start. Busy falls on the same edge.
- R7: A start sampled while busy is high has no effect on the running block's result or timing.
- R8: While busy is low, the ciphertext output does not change.
- R9: An active-low reset clears busy, done and the ciphertext output to zero, including when it arrives in the middle of a block.
- R10: A start given in the cycle where done is high is accepted, and the new block completes with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe; inputs are sampled with it |
| plaintext_i | input | 128 | Data block to encrypt, byte 0 in the top bits |
| key_i | input | 256 | Cipher key, byte 0 in the top bits |
| busy_o | output | 1 | High while rounds are running |
| done_o | output | 1 | One-cycle pulse when the ciphertext is ready |
| ciphertext_o | output | 128 | Result, held until the next accepted start |

## Verification
Known-answer vectors exercise the cipher with three kinds of input. An all-zero key and block isolates the S-box constant and the key schedule running from nothing. A counting key with a counting block exposes any byte-ordering or row-shift direction error. An unstructured key with two different blocks under it separates the data path from the key path. Back-to-back issue, a start while busy and a reset in the middle of a block check that control timing and the stored key window do not leak from one block into the next.

// File: rtl/aes256_pkg.sv
package aes256_pkg;
  localparam int BLK_W      = 128;
  localparam int KEY_W      = 256;
  localparam int WORD_W     = 32;
  localparam int NUM_ROUNDS = 14;
  localparam int NUM_BYTES  = BLK_W / 8;
  localparam int NUM_COLS   = BLK_W / WORD_W;
  localparam int ROUND_W    = $clog2(NUM_ROUNDS + 1);

  typedef logic [BLK_W-1:0]  blk_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [7:0]        byte_t;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic byte_t xtime(input byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gmul(input byte_t a, input byte_t b);
    byte_t acc = 8'h00;
    byte_t sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = xtime(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as x^254 (maps 0 to 0)
  function automatic byte_t ginv(input byte_t x);
    byte_t p = x;
    byte_t r = 8'h01;
    for (int i = 0; i < 7; i++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  // forward substitution box, computed: inverse then affine map
  function automatic byte_t sbox(input byte_t x);
    byte_t v = ginv(x);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]}
             ^ {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

  function automatic word_t sub_word(input word_t w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic word_t rot_word(input word_t w);
    return {w[23:0], w[31:24]};
  endfunction

  // round constant for index idx >= 1: 01 doubled idx-1 times
  function automatic byte_t rcon(input logic [ROUND_W-1:0] idx);
    byte_t r = 8'h01;
    for (int i = 1; i < NUM_ROUNDS; i++) begin
      if (ROUND_W'(i) < idx) r = xtime(r);
    end
    return r;
  endfunction

  function automatic blk_t sub_bytes(input blk_t v);
    blk_t o;
    for (int i = 0; i < NUM_BYTES; i++) o[BLK_W-1-8*i -: 8] = sbox(v[BLK_W-1-8*i -: 8]);
    return o;
  endfunction

  // row r of column c takes row r of column (c+r) mod 4
  function automatic blk_t shift_rows(input blk_t v);
    blk_t o;
    for (int c = 0; c < NUM_COLS; c++) begin
      for (int r = 0; r < 4; r++) begin
        o[BLK_W-1-8*(4*c+r) -: 8] = v[BLK_W-1-8*(4*((c+r)%NUM_COLS)+r) -: 8];
      end
    end
    return o;
  endfunction

  function automatic word_t mix_col(input word_t w);
    byte_t a0 = w[31:24];
    byte_t a1 = w[23:16];
    byte_t a2 = w[15:8];
    byte_t a3 = w[7:0];
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic blk_t mix_columns(input blk_t v);
    blk_t o;
    for (int c = 0; c < NUM_COLS; c++) o[BLK_W-1-WORD_W*c -: WORD_W] = mix_col(v[BLK_W-1-WORD_W*c -: WORD_W]);
    return o;
  endfunction
endpackage

// File: rtl/aes256_key_step.sv
module aes256_key_step
  import aes256_pkg::*;
(
  input  blk_t                older_i,
  input  blk_t                newer_i,
  input  logic [ROUND_W-1:0]  next_idx_i,
  output blk_t                next_o
);
  localparam int NW = BLK_W / WORD_W;

  word_t mix_w;
  word_t nw [NW];

  // even round keys carry rotation and round constant, odd ones substitution only
  always_comb begin
    if (next_idx_i[0] == 1'b0)
      mix_w = sub_word(rot_word(newer_i[WORD_W-1:0])) ^ {rcon(next_idx_i >> 1), 24'h0};
    else
      mix_w = sub_word(newer_i[WORD_W-1:0]);
  end

  assign nw[0] = older_i[BLK_W-1 -: WORD_W] ^ mix_w;

  for (genvar j = 1; j < NW; j++) begin : g_chain
    assign nw[j] = older_i[BLK_W-1-WORD_W*j -: WORD_W] ^ nw[j-1];
  end

  for (genvar j = 0; j < NW; j++) begin : g_pack
    assign next_o[BLK_W-1-WORD_W*j -: WORD_W] = nw[j];
  end
endmodule

// File: rtl/aes256_round.sv
module aes256_round
  import aes256_pkg::*;
(
  input  blk_t state_i,
  input  blk_t rkey_i,
  input  logic final_i,
  output blk_t state_o
);
  blk_t subbed;
  blk_t shifted;
  blk_t mixed;

  assign subbed  = sub_bytes(state_i);
  assign shifted = shift_rows(subbed);
  assign mixed   = mix_columns(shifted);
  assign state_o = (final_i ? shifted : mixed) ^ rkey_i;
endmodule

// File: rtl/aes256_enc.sv
module aes256_enc
  import aes256_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [BLK_W-1:0]   plaintext_i,
  input  logic [KEY_W-1:0]   key_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [BLK_W-1:0]   ciphertext_o
);
  localparam logic [ROUND_W-1:0] LAST = ROUND_W'(NUM_ROUNDS);

  blk_t               state_q;
  blk_t               kold_q;
  blk_t               knew_q;
  logic [ROUND_W-1:0] round_q;
  logic               busy_q;
  logic               done_q;

  // named events for the checker
  logic               accept_start;
  logic               last_round;
  logic [ROUND_W-1:0] next_idx;
  blk_t               round_out;
  blk_t               key_next;

  assign accept_start = start_i & ~busy_q;
  assign last_round   = busy_q & (round_q == LAST);
  assign next_idx     = round_q + 1'b1;

  aes256_round i_round (
    .state_i (state_q),
    .rkey_i  (knew_q),
    .final_i (last_round),
    .state_o (round_out)
  );

  aes256_key_step i_kstep (
    .older_i    (kold_q),
    .newer_i    (knew_q),
    .next_idx_i (next_idx),
    .next_o     (key_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      kold_q  <= '0;
      knew_q  <= '0;
      round_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_start) begin
        state_q <= plaintext_i ^ key_i[KEY_W-1 -: BLK_W];
        kold_q  <= key_i[KEY_W-1 -: BLK_W];
        knew_q  <= key_i[BLK_W-1:0];
        round_q <= ROUND_W'(1);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        state_q <= round_out;
        kold_q  <= knew_q;
        knew_q  <= key_next;
        if (last_round) begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          round_q <= '0;
        end else begin
          round_q <= next_idx;
        end
      end
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign ciphertext_o = state_q;
endmodule

// File: rtl/aes256_enc_chk.sv
module aes256_enc_chk #(
  parameter int RW   = 4,
  parameter int LAST = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [127:0]  ciphertext_o,
  input logic [RW-1:0] round_q,
  input logic          last_round
);
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && round_q == RW'(1))); // R5

  AST_ROUND_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (round_q >= RW'(1) && round_q <= RW'(LAST))); // R5

  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_round) |=> (busy_o && round_q == $past(round_q) + RW'(1))); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_round |=> (done_o && !busy_o)); // R6

  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(last_round)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6

  AST_CT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> (busy_o || $stable(ciphertext_o))); // R8
endmodule

bind aes256_enc aes256_enc_chk #(.RW(aes256_pkg::ROUND_W), .LAST(aes256_pkg::NUM_ROUNDS)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .ciphertext_o (ciphertext_o),
  .round_q      (round_q),
  .last_round   (last_round)
);

// File: tb/test_aes256_enc.sv
module test_aes256_enc;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] pt_i = '0;
  logic [255:0] key_i = '0;
  logic         busy_o;
  logic         done_o;
  logic [127:0] ciphertext_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  aes256_enc i_aes256_enc (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .plaintext_i  (pt_i),
    .key_i        (key_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .ciphertext_o (ciphertext_o)
  );

  // {key, plaintext, expected ciphertext}
  localparam int NV = 4;
  localparam logic [511:0] VECS [NV] = '{
    {256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
     128'h00112233445566778899aabbccddeeff, 128'h8ea2b7ca516745bfeafc49904b496089},
    {256'h0, 128'h0, 128'hdc95c078a2408989ad48a21492842087},
    {256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4,
     128'h6bc1bee22e409f96e93d7e117393172a, 128'hf3eed1bdb5d2a03c064b5a7e3db181f8},
    {256'h603deb1015ca71be2b73aef0857d77811f352c073b6108d72d9810a30914dff4,
     128'hae2d8a571e03ac9c9eb76fac45af8e51, 128'h591ccb10d410ed26dc5ba74a31362870}
  };

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge where done is seen
  task automatic run_block(input logic [255:0] k, input logic [127:0] p,
                           output logic [127:0] c, output int lat, output int busy_cnt);
    key_i = k; pt_i = p; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1; busy_cnt = 0;
    while (!done_o && lat < 40) begin
      if (busy_o) busy_cnt++;
      @(negedge clk);
      lat++;
    end
    c = ciphertext_o;
  endtask

  initial begin
    #(10 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] ct, ref_ct;
    int lat, bc;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R9 reset flags", {busy_o, done_o}, 0);
    chk(ciphertext_o == '0, "R9 reset ciphertext", ciphertext_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table, issued back to back (R10 from the second one on)
    for (int v = 0; v < NV; v++) begin
      run_block(VECS[v][511:256], VECS[v][255:128], ct, lat, bc);
      chk(ct == VECS[v][127:0], "R1 R2 R3 R4 known answer", ct, VECS[v][127:0]);
      chk(lat == 15, (v == 0) ? "R6 latency" : "R10 back-to-back latency", lat, 15);
      chk(bc == 14, "R5 busy length", bc, 14);
    end

    // R6 done is a single-cycle pulse; R8 result held while idle
    ref_ct = ciphertext_o;
    @(negedge clk);
    chk(done_o == 0, "R6 done pulse width", done_o, 0);
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        if (ciphertext_o !== ref_ct || done_o || busy_o) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R8 ciphertext held", bad, 0);
    end

    // R7 start while busy is ignored
    key_i = VECS[0][511:256]; pt_i = VECS[0][255:128]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    repeat (4) begin @(negedge clk); lat++; end
    key_i = VECS[2][511:256]; pt_i = VECS[2][255:128]; start_i = 1'b1;
    @(negedge clk); lat++;
    start_i = 1'b0;
    chk(busy_o == 1, "R7 still busy after ignored start", busy_o, 1);
    while (!done_o && lat < 40) begin @(negedge clk); lat++; end
    chk(lat == 15, "R7 latency unchanged", lat, 15);
    chk(ciphertext_o == VECS[0][127:0], "R7 result unchanged", ciphertext_o, VECS[0][127:0]);
    @(negedge clk);
    chk(busy_o == 0, "R7 no restart after ignored start", busy_o, 0);

    // R9 reset in the middle of a block
    key_i = VECS[3][511:256]; pt_i = VECS[3][255:128]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy_o == 0 && done_o == 0 && ciphertext_o == '0, "R9 mid-block reset",
        {busy_o, done_o, ciphertext_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_o == 0 && busy_o == 0, "R9 no completion after reset", {busy_o, done_o}, 0);

    // fresh block after reset still correct
    run_block(VECS[3][511:256], VECS[3][255:128], ct, lat, bc);
    chk(ct == VECS[3][127:0], "R4 known answer after reset", ct, VECS[3][127:0]);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule